// File: doc/BRIEF.md
# Header-Framed Serial Peripheral Transaction Master

This block runs one complete serial peripheral (SPI) transaction for each start command. It replaces a routine that toggles pins in software. The command sets the direction, which devices to select, a header of zero, one or two bytes, and a data length of 0 to 255 bytes. The block frames the transfer with its own select lines and drives the serial clock and serial out. Write data arrives one byte at a time on a valid/ready stream. Read data leaves as bytes, each marked by a one-cycle valid strobe.

Selection comes from a single active-high device mask. The physical select lines mix polarities: one line is active high and the others are active low. Some commands cannot be carried out: a least-significant-bit-first request, an undefined header code, or a read aimed at several devices at once. These end at once with an error status and never touch the bus.

Top module: `spi_txn_master`

## Requirements
- R1: `sel_o[0]` is high while mask bit 0 is selected. `sel_o[1]`, `sel_o[2]` and `sel_o[4]` to `sel_o[7]` go low while their mask bit is selected. `sel_o[3]` is always high. Outside a transaction, and in the cycle that reports done, `sel_o` is 8'hFE.
- R2: A read (`rd_i`=1) whose mask has more than one bit set returns `done_o`=1 and `ok_o`=0 two cycles after the start edge. No select is asserted and no clock pulse is sent. A write does not check the number of mask bits.
- R3: When `fmt_i[2]` (least-significant-bit-first request) is 1, the command returns `done_o`=1 and `ok_o`=0 two cycles after the start edge, with no bus activity.
- R4: `fmt_i[1:0]` selects the header. 0 sends no header. 1 sends `hdr_lo_i` only. 2 sends `hdr_hi_i` and then `hdr_lo_i`. 3 is an error with the same timing as R3.
- R5: Bytes are sent most significant bit first. Each bit holds `mosi_o` steady for H cycles with `sclk_o` low, followed by H cycles with `sclk_o` high. Every byte is preceded by a gap of at least one cycle with `sclk_o` low.
- R6: On a read, `miso_i` is sampled in the last cycle of each high clock phase. The first sampled bit becomes bit 7. After the last bit of each data byte, `rd_valid_o` pulses for one cycle with the byte on `rd_data_o`. `mosi_o` stays low during read data bytes.
- R7: A data length of 0 ends the transaction after the header.
- R8: After the last byte, one gap cycle follows. Then `done_o`=1 and `ok_o`=1 for one cycle, in the same cycle that `busy_o` falls and all selects return to inactive.
- R9: H equals `half_i` as sampled at start. Values below 2 are treated as 2.
- R10: `start_i` has no effect while `busy_o` is high.
- R11: `wr_ready_o` is high only in the gap before a write data byte. The gap, with `sclk_o` low, lasts until `wr_valid_i` is seen. The byte is taken in the cycle where both are high.
- R12: After reset, `busy_o`, `sclk_o`, `mosi_o`, `done_o`, `rd_valid_o` and `wr_ready_o` are 0, and `sel_o` is 8'hFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a transaction when idle |
| rd_i | input | 1 | 1 = read, 0 = write |
| mask_i | input | 8 | Active-high device mask |
| fmt_i | input | 3 | [1:0] header code, [2] bit-order request |
| hdr_hi_i | input | 8 | First header byte of a two-byte header |
| hdr_lo_i | input | 8 | Only or second header byte |
| len_i | input | LEN_W | Number of data bytes |
| half_i | input | DIV_W | Serial clock half-period in system clocks |
| wr_data_i | input | 8 | Write data byte |
| wr_valid_i | input | 1 | Write data byte present |
| wr_ready_o | output | 1 | Block takes a write byte |
| rd_data_o | output | 8 | Received data byte |
| rd_valid_o | output | 1 | One-cycle strobe for `rd_data_o` |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| ok_o | output | 1 | Status with `done_o`: 1 success, 0 error |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| sel_o | output | 8 | Physical device selects, mixed polarity |

## Verification
The error-path properties assume that command fields are sampled only on an idle start edge. They therefore key on `start_i` together with a low `busy_o`. The bench drives the command fields only in that cycle, except for one deliberate start issued during a transaction. The mosi hold property assumes that `half_i` is captured once per transaction. The bench never changes the effective period while a command is running. Write bytes are offered only in the gap the block opens, so the stall case comes purely from a late `wr_valid_i`.

// File: rtl/spi_txn_pkg.sv
// Shared types and helpers for the transaction master.
// Assumes an 8-bit byte and an 8-bit device mask.
package spi_txn_pkg;
    localparam int BYTE_W = 8;
    localparam int MASK_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FAIL,
        ST_NEXT,
        ST_SHIFT
    } txn_state_t;

    localparam logic [1:0] HDR_BAD = 2'd3;

    // Number of set bits in a mask.
    function automatic logic [3:0] count_ones(input logic [MASK_W-1:0] v);
        logic [3:0] n;
        n = '0;
        for (int i = 0; i < MASK_W; i++) n = n + {3'b000, v[i]};
        return n;
    endfunction
endpackage

// File: rtl/spi_sel_map.sv
// Maps an active-high select mask to physical select pins.
// Bits in HIGH_MASK are active high. Bits in SPARE_MASK stay inactive high.
// All other bits are active low. Purely combinational.
module spi_sel_map #(
    parameter int              W          = 8,
    parameter logic [W-1:0]    HIGH_MASK  = 8'h01,
    parameter logic [W-1:0]    SPARE_MASK = 8'h08
) (
    input  logic [W-1:0] act_i,
    output logic [W-1:0] sel_o
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        if (HIGH_MASK[i]) begin : g_hi
            assign sel_o[i] = act_i[i];
        end else begin : g_lo
            assign sel_o[i] = ~(act_i[i] & ~SPARE_MASK[i]);
        end
    end
endmodule

// File: rtl/spi_bit_shifter.sv
// Shifts one byte out, most significant bit first, and one byte in.
// Each bit has half_i cycles with the clock low, then half_i cycles high.
// The input is sampled on the last high cycle.
// Assumes half_i >= 2 and half_i held stable while a byte is shifted.
module spi_bit_shifter #(
    parameter int DIV_W  = 8,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] tx_i,
    input  logic [DIV_W-1:0]  half_i,
    input  logic              miso_i,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              last_o,
    output logic [BYTE_W-1:0] rx_next_o
);
    localparam int BIT_W = $clog2(BYTE_W);

    logic              active_q;
    logic              phase_q;
    logic [DIV_W-1:0]  cnt_q;
    logic [BIT_W-1:0]  bitn_q;
    logic [BYTE_W-1:0] txsh_q;
    logic [BYTE_W-1:0] rxsh_q;
    logic              half_end;

    assign half_end  = active_q && (cnt_q == half_i - DIV_W'(1));
    assign last_o    = half_end && phase_q && (bitn_q == BIT_W'(BYTE_W - 1));
    assign rx_next_o = {rxsh_q[BYTE_W-2:0], miso_i};
    assign sclk_o    = phase_q;
    assign mosi_o    = txsh_q[BYTE_W-1];

    // Half-period counter, clock phase, bit index and shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            phase_q  <= 1'b0;
            cnt_q    <= '0;
            bitn_q   <= '0;
            txsh_q   <= '0;
            rxsh_q   <= '0;
        end else if (load_i) begin
            active_q <= 1'b1;
            phase_q  <= 1'b0;
            cnt_q    <= '0;
            bitn_q   <= '0;
            txsh_q   <= tx_i;
        end else if (active_q) begin
            if (half_end) begin
                cnt_q <= '0;
                if (!phase_q) begin
                    phase_q <= 1'b1;
                end else begin
                    phase_q <= 1'b0;
                    rxsh_q  <= rx_next_o;
                    txsh_q  <= txsh_q << 1;
                    bitn_q  <= bitn_q + BIT_W'(1);
                    if (bitn_q == BIT_W'(BYTE_W - 1)) active_q <= 1'b0;
                end
            end else begin
                cnt_q <= cnt_q + DIV_W'(1);
            end
        end
    end
endmodule

// File: rtl/spi_txn_master.sv
// Runs one serial transaction per idle start command: an optional header,
// then len_i data bytes.
// Rejects bit-order requests, undefined header codes and multi-device
// reads with an error. Assumes the write stream offers a byte only when
// wr_ready_o is high.
module spi_txn_master
    import spi_txn_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rd_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic [2:0]        fmt_i,
    input  logic [BYTE_W-1:0] hdr_hi_i,
    input  logic [BYTE_W-1:0] hdr_lo_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [DIV_W-1:0]  half_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              wr_valid_i,
    output logic              wr_ready_o,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              ok_o,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic [MASK_W-1:0] sel_o
);
    localparam logic [DIV_W-1:0] HALF_MIN = DIV_W'(2);

    txn_state_t        state_q;
    logic              rd_q;
    logic              data_q;
    logic [1:0]        hdr_left_q;
    logic [BYTE_W-1:0] hh_q;
    logic [BYTE_W-1:0] hl_q;
    logic [LEN_W-1:0]  left_q;
    logic [DIV_W-1:0]  half_q;
    logic [MASK_W-1:0] sel_act_q;
    logic              done_q;
    logic              ok_q;
    logic              rdv_q;
    logic [BYTE_W-1:0] rdd_q;

    logic              cmd_err;
    logic              hdr_go;
    logic              data_go;
    logic              load;
    logic              finish;
    logic [BYTE_W-1:0] load_byte;
    logic              last;
    logic [BYTE_W-1:0] rx_next;

    // Decode command legality at the start edge.
    always_comb begin
        cmd_err = fmt_i[2] || (fmt_i[1:0] == HDR_BAD) ||
                  (rd_i && (count_ones(mask_i) > 4'd1));
    end

    // Pick the next byte to send while in the gap state.
    always_comb begin
        hdr_go  = (state_q == ST_NEXT) && (hdr_left_q != 2'd0);
        data_go = (state_q == ST_NEXT) && (hdr_left_q == 2'd0) && (left_q != '0);
        finish  = (state_q == ST_NEXT) && (hdr_left_q == 2'd0) && (left_q == '0);
        load    = hdr_go || (data_go && (rd_q || wr_valid_i));
        if (hdr_left_q == 2'd2)      load_byte = hh_q;
        else if (hdr_left_q == 2'd1) load_byte = hl_q;
        else if (rd_q)               load_byte = '0;
        else                         load_byte = wr_data_i;
    end

    assign wr_ready_o = data_go && !rd_q;
    assign busy_o     = (state_q != ST_IDLE);
    assign done_o     = done_q;
    assign ok_o       = ok_q;
    assign rd_valid_o = rdv_q;
    assign rd_data_o  = rdd_q;

    // Transaction sequencing: capture, header, data, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            rd_q       <= 1'b0;
            data_q     <= 1'b0;
            hdr_left_q <= 2'd0;
            hh_q       <= '0;
            hl_q       <= '0;
            left_q     <= '0;
            half_q     <= HALF_MIN;
            sel_act_q  <= '0;
            done_q     <= 1'b0;
            ok_q       <= 1'b0;
            rdv_q      <= 1'b0;
            rdd_q      <= '0;
        end else begin
            done_q <= 1'b0;
            rdv_q  <= 1'b0;
            case (state_q)
                ST_IDLE: if (start_i) begin
                    rd_q       <= rd_i;
                    hh_q       <= hdr_hi_i;
                    hl_q       <= hdr_lo_i;
                    left_q     <= len_i;
                    hdr_left_q <= fmt_i[1:0];
                    half_q     <= (half_i < HALF_MIN) ? HALF_MIN : half_i;
                    if (cmd_err) begin
                        state_q <= ST_FAIL;
                    end else begin
                        state_q   <= ST_NEXT;
                        sel_act_q <= mask_i;
                    end
                end
                ST_FAIL: begin
                    done_q  <= 1'b1;
                    ok_q    <= 1'b0;
                    state_q <= ST_IDLE;
                end
                ST_NEXT: begin
                    if (hdr_go) begin
                        hdr_left_q <= hdr_left_q - 2'd1;
                        data_q     <= 1'b0;
                        state_q    <= ST_SHIFT;
                    end else if (load) begin
                        left_q  <= left_q - LEN_W'(1);
                        data_q  <= 1'b1;
                        state_q <= ST_SHIFT;
                    end else if (finish) begin
                        done_q    <= 1'b1;
                        ok_q      <= 1'b1;
                        sel_act_q <= '0;
                        state_q   <= ST_IDLE;
                    end
                end
                ST_SHIFT: if (last) begin
                    state_q <= ST_NEXT;
                    if (data_q && rd_q) begin
                        rdv_q <= 1'b1;
                        rdd_q <= rx_next;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    spi_bit_shifter #(
        .DIV_W  (DIV_W),
        .BYTE_W (BYTE_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .tx_i      (load_byte),
        .half_i    (half_q),
        .miso_i    (miso_i),
        .sclk_o    (sclk_o),
        .mosi_o    (mosi_o),
        .last_o    (last),
        .rx_next_o (rx_next)
    );

    spi_sel_map #(
        .W          (MASK_W),
        .HIGH_MASK  (8'h01),
        .SPARE_MASK (8'h08)
    ) u_sel (
        .act_i (sel_act_q),
        .sel_o (sel_o)
    );
endmodule

// File: rtl/spi_txn_master_chk.sv
// Port-level properties of the transaction master, bound to every instance.
module spi_txn_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       rd_i,
    input logic [7:0] mask_i,
    input logic [2:0] fmt_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       ok_o,
    input logic       sclk_o,
    input logic       mosi_o,
    input logic [7:0] sel_o,
    input logic       wr_ready_o,
    input logic       rd_valid_o
);
    localparam logic [7:0] SEL_IDLE = 8'hFE;

    assert_spare_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_o[3]);
    assert_idle_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (sel_o == SEL_IDLE));
    assert_multi_read_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && rd_i && ($countones(mask_i) > 1)) |=> ##1 (done_o && !ok_o));
    assert_multi_read_nosel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && rd_i && ($countones(mask_i) > 1)) |=> (sel_o == SEL_IDLE && !sclk_o));
    assert_order_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && fmt_i[2]) |=> ##1 (done_o && !ok_o));
    assert_hdr_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && fmt_i[1:0] == 2'd3) |=> ##1 (done_o && !ok_o));
    assert_idle_clk_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sclk_o);
    assert_mosi_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
    assert_high_min_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |=> sclk_o);
    assert_rdv_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |=> !rd_valid_o);
    assert_rdv_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> (busy_o && !sclk_o));
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    assert_ready_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready_o |-> (busy_o && !sclk_o));
endmodule

bind spi_txn_master spi_txn_master_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rd_i       (rd_i),
    .mask_i     (mask_i),
    .fmt_i      (fmt_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .ok_o       (ok_o),
    .sclk_o     (sclk_o),
    .mosi_o     (mosi_o),
    .sel_o      (sel_o),
    .wr_ready_o (wr_ready_o),
    .rd_valid_o (rd_valid_o)
);

// File: tb/spi_txn_master_bench.sv
// Bench: each transaction is expanded into a per-cycle list of stimulus and
// expected outputs built from the requirements, then replayed and compared.
module spi_txn_master_bench;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       rd_i = 1'b0;
    logic [7:0] mask_i = '0;
    logic [2:0] fmt_i = '0;
    logic [7:0] hdr_hi_i = '0;
    logic [7:0] hdr_lo_i = '0;
    logic [7:0] len_i = '0;
    logic [7:0] half_i = '0;
    logic [7:0] wr_data_i = '0;
    logic       wr_valid_i = 1'b0;
    logic       miso_i = 1'b0;
    logic       wr_ready_o;
    logic [7:0] rd_data_o;
    logic       rd_valid_o;
    logic       busy_o;
    logic       done_o;
    logic       ok_o;
    logic       sclk_o;
    logic       mosi_o;
    logic [7:0] sel_o;

    int checks = 0;
    int failures = 0;

    spi_txn_master u_spi_txn_master (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .rd_i (rd_i),
        .mask_i (mask_i), .fmt_i (fmt_i), .hdr_hi_i (hdr_hi_i),
        .hdr_lo_i (hdr_lo_i), .len_i (len_i), .half_i (half_i),
        .wr_data_i (wr_data_i), .wr_valid_i (wr_valid_i),
        .wr_ready_o (wr_ready_o), .rd_data_o (rd_data_o),
        .rd_valid_o (rd_valid_o), .busy_o (busy_o), .done_o (done_o),
        .ok_o (ok_o), .sclk_o (sclk_o), .mosi_o (mosi_o),
        .miso_i (miso_i), .sel_o (sel_o)
    );

    always #(PERIOD/2) clk = ~clk;

    typedef struct {
        logic       d_start, d_rd, d_wv, d_miso;
        logic [7:0] d_mask, d_hh, d_hl, d_len, d_half, d_wd;
        logic [2:0] d_fmt;
        logic       e_busy, e_sclk, e_mosi, e_done, e_ok, e_rdv, e_wrdy;
        logic [7:0] e_sel, e_rdd;
    } cyc_t;

    cyc_t       plan[$];
    string      cur_tag;
    logic [7:0] cur_sel;
    int         wdat[$];
    int         stl[$];
    int         rdat[$];

    function automatic cyc_t idle_e();
        cyc_t e;
        e = '{default: '0};
        e.e_sel = 8'hFE;
        return e;
    endfunction

    function automatic cyc_t act_e();
        cyc_t e;
        e = idle_e();
        e.e_busy = 1'b1;
        e.e_sel  = cur_sel;
        return e;
    endfunction

    // Physical select levels expected for a mask (R1).
    function automatic logic [7:0] sel_of(input logic [7:0] m);
        logic [7:0] s;
        s = 8'hFE;
        if (m[0]) s[0] = 1'b1;
        for (int i = 1; i < 8; i++) if (i != 3 && m[i]) s[i] = 1'b0;
        return s;
    endfunction

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%0h exp=%0h at %0t", cur_tag, what, act, exp, $time);
        end
    endtask

    task automatic run_plan();
        while (plan.size() > 0) begin
            cyc_t e;
            e = plan.pop_front();
            @(negedge clk);
            chk("busy", {7'd0, busy_o}, {7'd0, e.e_busy});
            chk("sclk", {7'd0, sclk_o}, {7'd0, e.e_sclk});
            chk("mosi", {7'd0, mosi_o}, {7'd0, e.e_mosi});
            chk("sel", sel_o, e.e_sel);
            chk("done", {7'd0, done_o}, {7'd0, e.e_done});
            chk("wr_ready", {7'd0, wr_ready_o}, {7'd0, e.e_wrdy});
            chk("rd_valid", {7'd0, rd_valid_o}, {7'd0, e.e_rdv});
            if (e.e_done) chk("ok", {7'd0, ok_o}, {7'd0, e.e_ok});
            if (e.e_rdv) chk("rd_data", rd_data_o, e.e_rdd);
            start_i = e.d_start; rd_i = e.d_rd; mask_i = e.d_mask; fmt_i = e.d_fmt;
            hdr_hi_i = e.d_hh; hdr_lo_i = e.d_hl; len_i = e.d_len; half_i = e.d_half;
            wr_valid_i = e.d_wv; wr_data_i = e.d_wd; miso_i = e.d_miso;
        end
    endtask

    // Expand one command into expected cycles from R1-style rules listed in the brief.
    task automatic plan_txn(input string tag, input logic rd, input logic [7:0] mask,
                            input logic [2:0] fmt, input logic [7:0] hh, input logic [7:0] hl,
                            input logic [7:0] len, input logic [7:0] half, input bit inject);
        cyc_t e;
        int   h;
        bit   err;
        int   bv[$];
        bit   bd[$];
        int   bst[$];
        int   brx[$];
        bit   pend;
        logic [7:0] pendv;
        bit   injected;
        cur_tag = tag;
        cur_sel = sel_of(mask);
        h = (half < 2) ? 2 : half;
        err = fmt[2] || (fmt[1:0] == 2'd3) || (rd && $countones(mask) > 1);
        e = idle_e();
        e.d_start = 1'b1; e.d_rd = rd; e.d_mask = mask; e.d_fmt = fmt;
        e.d_hh = hh; e.d_hl = hl; e.d_len = len; e.d_half = half;
        plan.push_back(e);
        if (err) begin
            e = idle_e(); e.e_busy = 1'b1; plan.push_back(e);
            e = idle_e(); e.e_done = 1'b1; e.e_ok = 1'b0; plan.push_back(e);
            plan.push_back(idle_e());
            run_plan();
            return;
        end
        if (fmt[1:0] == 2'd2) begin bv.push_back(hh); bd.push_back(0); bst.push_back(0); brx.push_back(0); end
        if (fmt[1:0] != 2'd0) begin bv.push_back(hl); bd.push_back(0); bst.push_back(0); brx.push_back(0); end
        for (int k = 0; k < len; k++) begin
            bv.push_back(rd ? 0 : wdat[k]);
            bd.push_back(1);
            bst.push_back(rd ? 0 : stl[k]);
            brx.push_back(rd ? rdat[k] : 0);
        end
        pend = 0; pendv = '0; injected = 0;
        for (int b = 0; b < bv.size(); b++) begin
            logic [7:0] v;
            logic [7:0] r;
            bit wdb;
            int gaps;
            v = bv[b][7:0]; r = brx[b][7:0];
            wdb = bd[b] && !rd;
            gaps = wdb ? bst[b] + 1 : 1;
            for (int g = 0; g < gaps; g++) begin
                e = act_e();
                e.e_wrdy = wdb;
                e.d_wv = wdb && (g == gaps - 1);
                e.d_wd = v;
                if (pend && g == 0) begin e.e_rdv = 1'b1; e.e_rdd = pendv; pend = 0; end
                plan.push_back(e);
            end
            for (int i = 7; i >= 0; i--) begin
                for (int ph = 0; ph < 2; ph++) begin
                    for (int c = 0; c < h; c++) begin
                        e = act_e();
                        e.e_sclk = ph[0];
                        e.e_mosi = (bd[b] && rd) ? 1'b0 : v[i];
                        e.d_miso = r[i];
                        if (inject && !injected) begin
                            // R10: an error-type start while busy must be ignored
                            e.d_start = 1'b1; e.d_rd = 1'b1; e.d_mask = 8'hFF; e.d_fmt = 3'b111;
                            injected = 1;
                        end
                        plan.push_back(e);
                    end
                end
            end
            if (bd[b] && rd) begin pend = 1; pendv = r; end
        end
        e = act_e();
        if (pend) begin e.e_rdv = 1'b1; e.e_rdd = pendv; end
        plan.push_back(e);
        e = idle_e(); e.e_done = 1'b1; e.e_ok = 1'b1; plan.push_back(e);
        plan.push_back(idle_e());
        run_plan();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(PERIOD * 150000);
        failures++;
        $display("FAIL R8 watchdog act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        cur_tag = "R12";
        @(negedge clk);
        chk("busy", {7'd0, busy_o}, 8'd0);
        chk("sclk", {7'd0, sclk_o}, 8'd0);
        chk("mosi", {7'd0, mosi_o}, 8'd0);
        chk("sel", sel_o, 8'hFE);
        chk("done", {7'd0, done_o}, 8'd0);
        chk("rd_valid", {7'd0, rd_valid_o}, 8'd0);
        chk("wr_ready", {7'd0, wr_ready_o}, 8'd0);

        // R5: two-byte header then two data bytes, MSB first
        wdat = '{8'h81, 8'h7E}; stl = '{0, 3};
        plan_txn("R5", 1'b0, 8'h01, 3'b010, 8'hA5, 8'h3C, 8'd2, 8'd2, 0);

        // R11: write stream stalls, multi-device write allowed (R2)
        wdat = '{8'hC6, 8'h00, 8'hFF}; stl = '{2, 0, 5};
        plan_txn("R11", 1'b0, 8'hF6, 3'b000, 8'h00, 8'h00, 8'd3, 8'd2, 0);

        // R6: read with one-byte header, half period 3
        rdat = '{8'hC3, 8'h01, 8'hFE};
        plan_txn("R6", 1'b1, 8'h10, 3'b001, 8'h00, 8'h5A, 8'd3, 8'd3, 0);

        // R7: header only
        plan_txn("R7", 1'b0, 8'h04, 3'b010, 8'h12, 8'h34, 8'd0, 8'd2, 0);

        // R4: undefined header code
        plan_txn("R4", 1'b0, 8'h02, 3'b011, 8'h00, 8'h00, 8'd1, 8'd2, 0);

        // R2: read aimed at two devices
        plan_txn("R2", 1'b1, 8'h12, 3'b000, 8'h00, 8'h00, 8'd1, 8'd2, 0);

        // R3: bit-order request
        plan_txn("R3", 1'b0, 8'h01, 3'b100, 8'h00, 8'h00, 8'd1, 8'd2, 0);

        // R9: half period 0 behaves as 2
        rdat = '{8'h96};
        plan_txn("R9", 1'b1, 8'h80, 3'b000, 8'h00, 8'h00, 8'd1, 8'd0, 0);

        // R10: start during a transaction is ignored
        wdat = '{8'h5B}; stl = '{1};
        plan_txn("R10", 1'b0, 8'h40, 3'b001, 8'h00, 8'hE7, 8'd1, 8'd2, 1);

        // R1: spare mask bit drives no select
        rdat = '{8'h3D};
        plan_txn("R1", 1'b1, 8'h08, 3'b000, 8'h00, 8'h00, 8'd1, 8'd2, 0);

        // R8: empty transaction completes with success
        plan_txn("R8", 1'b0, 8'h20, 3'b000, 8'h00, 8'h00, 8'd0, 8'd2, 0);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule